// File: doc/BRIEF.md
# Strobe-Driven Frequency Hop Sequencer

This block holds a small byte-wide register bank containing two tables of eight 32-bit tuning words each. The first table feeds a frequency synthesizer and the second feeds a digital oscillator that shifts the signal down to baseband. An active index picks one entry from each table, and the two selected words are driven out continuously. A one-cycle flag marks every cycle in which the index moves, so that downstream logic knows when to reload the synthesizer and the oscillator.

The index has two sources. With hopping switched off, software writes the index directly into a field of the control byte. With hopping switched on, an asynchronous strobe pin steps the index through a round-robin list of programmable length N (1 to 8). Each rising edge of the strobe moves the index one step. The strobe is synchronized to the system clock and reduced to a single-cycle event before it reaches the index logic.

Top module: `hop_seq_top`

## Requirements
- R1: After reset every register byte reads as zero, both selected words are zero and the change flag is low.
- R2: Byte addresses 0 to 67 are writable and read back the last value written. Reads at addresses 68 and above return zero. Writes at addresses 68 and above have no effect.
- R3: Synthesizer entry 0 is bytes 0..3, and entry x (1..7) is bytes 3+4x..6+4x. The lowest address holds the least significant byte.
- R4: Oscillator entry x (0..7) is bytes 36+4x..39+4x. The lowest address holds the least significant byte.
- R5: While bit 2 of control byte 6 is 0, the active index equals bits 7:5 of byte 6. It takes effect on the second clock edge after the write.
- R6: While bit 2 of byte 6 is 1, each rising edge of the strobe advances the index by one, modulo N, where N is byte 35. The new index shows on the third clock edge after the strobe rises.
- R7: An N value of 0, or of more than 8, acts as N = 8.
- R8: If the index is at or above N when a strobe arrives, the index goes to 0.
- R9: The change flag is high for exactly one cycle per index change. It is high in the same cycle that the new words first appear, and it stays low when a strobe leaves the index unchanged.
- R10: A strobe held high for many cycles advances the index only once. The strobe must stay high, and then low, for at least two clock cycles each.
- R11: When hopping is switched on, the sequence continues from the index software had selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register bank |
| wr_addr | input | 7 | Write byte address |
| wr_data | input | 8 | Write byte |
| rd_addr | input | 7 | Read byte address |
| rd_data | output | 8 | Read byte (combinational) |
| hop_strobe | input | 1 | Asynchronous hop request, rising-edge active |
| synth_word | output | 32 | Selected synthesizer tuning word |
| nco_word | output | 32 | Selected oscillator tuning word |
| word_chg | output | 1 | One-cycle pulse on every index change |

## Verification
The index is not visible as a port, so a wrong index shows up as a wrong pair of tuning words. The bench gives every table entry a distinct value, which means any index error is seen within three clock edges of the strobe or two edges of a control write. An error in the strobe edge detector shows up as a missing step, or as extra steps while the strobe is held high. A misplaced change pulse is caught by counting pulses per strobe and by latching the word that is present while the pulse is high.

// File: rtl/hop_pkg.sv
package hop_pkg;
    localparam int NUM_ENT    = 8;
    localparam int IDX_W      = $clog2(NUM_ENT);
    localparam int NUM_REGS   = 68;
    localparam int ADDR_W     = $clog2(NUM_REGS);
    localparam int CTRL_ADDR  = 6;
    localparam int COUNT_ADDR = 35;
    localparam int NCO_BASE   = 36;
    localparam int EXT_BIT    = 2;
    localparam int SW_LSB     = 5;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             chg;
    } hop_state_t;

    function automatic int synth_base(input int x);
        return (x == 0) ? 0 : 3 + 4 * x;
    endfunction

    function automatic int nco_base(input int x);
        return NCO_BASE + 4 * x;
    endfunction
endpackage

// File: rtl/hop_regbank.sv
module hop_regbank
    import hop_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [ADDR_W-1:0]               wr_addr,
    input  logic [7:0]                      wr_data,
    input  logic [ADDR_W-1:0]               rd_addr,
    output logic [7:0]                      rd_data,
    output logic [NUM_ENT-1:0][31:0]        synth_tab,
    output logic [NUM_ENT-1:0][31:0]        nco_tab,
    output logic [7:0]                      ctrl_byte,
    output logic [7:0]                      count_byte
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_REGS - 1);

    logic [7:0] regs_q [NUM_REGS];
    logic [7:0] regs_d [NUM_REGS];

    always_comb begin
        for (int i = 0; i < NUM_REGS; i++) regs_d[i] = regs_q[i];
        if (wr_en && (wr_addr <= LAST_ADDR)) regs_d[wr_addr] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= '0;
        end else begin
            for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= regs_d[i];
        end
    end

    assign rd_data    = (rd_addr <= LAST_ADDR) ? regs_q[rd_addr] : 8'h00;
    assign ctrl_byte  = regs_q[CTRL_ADDR];
    assign count_byte = regs_q[COUNT_ADDR];

    for (genvar x = 0; x < NUM_ENT; x++) begin : g_tab
        localparam int SB = synth_base(x);
        localparam int NB = nco_base(x);
        assign synth_tab[x] = {regs_q[SB+3], regs_q[SB+2], regs_q[SB+1], regs_q[SB]};
        assign nco_tab[x]   = {regs_q[NB+3], regs_q[NB+2], regs_q[NB+1], regs_q[NB]};
    end

    AST_CTRL_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(CTRL_ADDR)) |=> ctrl_byte == $past(wr_data)); // R2
endmodule

// File: rtl/hop_strobe_sync.sv
module hop_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_async,
    output logic strobe_pulse
);
    localparam int LEN = STAGES + 1;

    logic [LEN-1:0] sync_q;
    logic [LEN-1:0] sync_d;

    always_comb begin
        sync_d = {sync_q[LEN-2:0], strobe_async};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign strobe_pulse = sync_q[STAGES-1] & ~sync_q[STAGES];

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_pulse |=> !strobe_pulse); // R10
endmodule

// File: rtl/hop_index.sv
module hop_index
    import hop_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       ctrl_byte,
    input  logic [7:0]       count_byte,
    input  logic             strobe_pulse,
    output logic [IDX_W-1:0] idx,
    output logic             chg
);
    localparam logic [IDX_W:0] FULL = (IDX_W+1)'(NUM_ENT);

    hop_state_t st_q, st_d;
    logic             ext_en;
    logic [IDX_W-1:0] sw_idx;
    logic [IDX_W:0]   n_eff;
    logic [IDX_W:0]   idx_inc;

    always_comb begin
        ext_en  = ctrl_byte[EXT_BIT];
        sw_idx  = ctrl_byte[SW_LSB +: IDX_W];
        n_eff   = (count_byte == 8'd0 || count_byte > 8'(NUM_ENT)) ? FULL : count_byte[IDX_W:0];
        idx_inc = {1'b0, st_q.idx} + 1'b1;
        st_d    = st_q;
        if (!ext_en) begin
            st_d.idx = sw_idx;
        end else if (strobe_pulse) begin
            st_d.idx = (idx_inc >= n_eff) ? '0 : idx_inc[IDX_W-1:0];
        end
        st_d.chg = (st_d.idx != st_q.idx);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign idx = st_q.idx;
    assign chg = st_q.chg;

    AST_SW_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_en |=> idx == $past(sw_idx)); // R5
    AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_en && !strobe_pulse) |=> $stable(idx)); // R6
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_en && strobe_pulse && ({1'b0, idx} + 1'b1 >= n_eff)) |=> idx == '0); // R8
    AST_CHG_ON_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        ##1 (chg == (idx != $past(idx)))); // R9
endmodule

// File: rtl/hop_seq_top.sv
module hop_seq_top
    import hop_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    input  logic              hop_strobe,
    output logic [31:0]       synth_word,
    output logic [31:0]       nco_word,
    output logic              word_chg
);
    logic [NUM_ENT-1:0][31:0] synth_tab;
    logic [NUM_ENT-1:0][31:0] nco_tab;
    logic [7:0]               ctrl_byte;
    logic [7:0]               count_byte;
    logic                     strobe_pulse;
    logic [IDX_W-1:0]         idx;

    hop_regbank u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .synth_tab  (synth_tab),
        .nco_tab    (nco_tab),
        .ctrl_byte  (ctrl_byte),
        .count_byte (count_byte)
    );

    hop_strobe_sync #(.STAGES(2)) u_sync (
        .clk          (clk),
        .rst_n        (rst_n),
        .strobe_async (hop_strobe),
        .strobe_pulse (strobe_pulse)
    );

    hop_index u_idx (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl_byte    (ctrl_byte),
        .count_byte   (count_byte),
        .strobe_pulse (strobe_pulse),
        .idx          (idx),
        .chg          (chg_int)
    );

    logic chg_int;

    assign synth_word = synth_tab[idx];
    assign nco_word   = nco_tab[idx];
    assign word_chg   = chg_int;
endmodule

// File: tb/hop_seq_top_tb_top.sv
module hop_seq_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 11;
    // {sw_idx[2:0], count[7:0], strobes[7:0], expected_idx[2:0]}
    localparam logic [21:0] VEC [NVEC] = '{
        {3'd0, 8'd4,   8'd0, 3'd0},
        {3'd0, 8'd4,   8'd3, 3'd3},
        {3'd0, 8'd4,   8'd5, 3'd1},
        {3'd2, 8'd4,   8'd1, 3'd3},
        {3'd2, 8'd4,   8'd2, 3'd0},
        {3'd0, 8'd1,   8'd3, 3'd0},
        {3'd0, 8'd0,   8'd9, 3'd1},
        {3'd0, 8'd200, 8'd7, 3'd7},
        {3'd6, 8'd3,   8'd1, 3'd0},
        {3'd5, 8'd8,   8'd3, 3'd0},
        {3'd1, 8'd2,   8'd1, 3'd0}
    };

    logic       clk = 0;
    logic       rst_n = 0;
    logic       wr_en = 0;
    logic [6:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [6:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       hop_strobe = 0;
    logic [31:0] synth_word, nco_word;
    logic       word_chg;

    int n_tests = 0;
    int n_fail  = 0;
    int chg_cnt = 0;
    logic [31:0] chg_word = '0;
    bit  done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hop_seq_top dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .hop_strobe(hop_strobe), .synth_word(synth_word),
        .nco_word(nco_word), .word_chg(word_chg)
    );

    always @(negedge clk) if (rst_n && word_chg) begin
        chg_cnt++;
        chg_word = synth_word;
    end

    function automatic logic [31:0] sval(input int x);
        return 32'hC0DE_0000 | (x << 8) | (x * 3 + 1);
    endfunction
    function automatic logic [31:0] nval(input int x);
        return 32'h7E00_0000 | (x << 16) | (x * 5 + 2);
    endfunction
    function automatic int sbase(input int x);
        return (x == 0) ? 0 : 3 + 4 * x;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = 7'(a); wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic wr_word(input int base, input logic [31:0] w);
        for (int b = 0; b < 4; b++) wr(base + b, w[8*b +: 8]);
    endtask

    task automatic strobe(input int hi);
        @(negedge clk);
        hop_strobe = 1;
        repeat (hi) @(negedge clk);
        hop_strobe = 0;
        repeat (4) @(negedge clk);
    endtask

    task automatic rd(input int a, output logic [7:0] d);
        rd_addr = 7'(a);
        #1;
        d = rd_data;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] b;
        int c0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        rd(6, b);  chk(b == 0, "R1 ctrl", {24'h0, b}, 0);
        rd(35, b); chk(b == 0, "R1 count", {24'h0, b}, 0);
        chk(synth_word == 0, "R1 synth", synth_word, 0);
        chk(nco_word == 0, "R1 nco", nco_word, 0);
        chk(word_chg == 0, "R1 chg", {31'h0, word_chg}, 0);

        // load tables
        for (int x = 0; x < 8; x++) begin
            wr_word(sbase(x), sval(x));
            wr_word(36 + 4 * x, nval(x));
        end
        @(negedge clk);
        chk(synth_word == sval(0), "R3 entry0", synth_word, sval(0));
        chk(nco_word == nval(0), "R4 entry0", nco_word, nval(0));

        // R2 readback and out-of-range
        wr(4, 8'h3C);
        rd(4, b);  chk(b == 8'h3C, "R2 readback", {24'h0, b}, 32'h3C);
        rd(8, b);  chk(b == sval(1)[15:8], "R2 R3 byte order", {24'h0, b}, {24'h0, sval(1)[15:8]});
        wr(100, 8'hAA);
        rd(100, b); chk(b == 0, "R2 high read", {24'h0, b}, 0);
        rd(67, b);  chk(b == nval(7)[31:24], "R2 last byte", {24'h0, b}, {24'h0, nval(7)[31:24]});

        // vector walk
        for (int v = 0; v < NVEC; v++) begin
            logic [2:0] sw, ex;
            logic [7:0] cn, ns;
            {sw, cn, ns, ex} = VEC[v];
            wr(6, {sw, 5'b00000});
            @(negedge clk);
            chk(synth_word == sval(sw), "R5 sw select", synth_word, sval(sw));
            wr(35, cn);
            wr(6, {sw, 5'b00100});
            for (int s = 0; s < ns; s++) strobe(3);
            // R6 R7 R8 R11 round-robin steps
            chk(synth_word == sval(ex), "R6 R3 synth after hops", synth_word, sval(ex));
            chk(nco_word == nval(ex), "R6 R4 nco after hops", nco_word, nval(ex));
        end

        // R9 one pulse per change, coincident with new word
        wr(6, 8'h00); wr(35, 8'd8); wr(6, 8'h04);
        @(negedge clk);
        c0 = chg_cnt;
        strobe(3);
        chk(chg_cnt - c0 == 1, "R9 pulse count", chg_cnt - c0, 1);
        chk(chg_word == sval(1), "R9 word at pulse", chg_word, sval(1));

        // R10 long strobe advances once
        strobe(20);
        chk(synth_word == sval(2), "R10 long strobe", synth_word, sval(2));

        // R9 no pulse when index unchanged (N=1 at index 0)
        wr(6, 8'h00); wr(35, 8'd1); wr(6, 8'h04);
        @(negedge clk);
        c0 = chg_cnt;
        strobe(3);
        chk(chg_cnt - c0 == 0, "R9 no pulse", chg_cnt - c0, 0);
        chk(synth_word == sval(0), "R6 N=1 stays", synth_word, sval(0));

        // R5 strobe ignored while hopping disabled
        wr(6, 8'h60);
        strobe(3);
        chk(synth_word == sval(3), "R5 strobe ignored", synth_word, sval(3));

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule